// File: doc/BRIEF.md
# Top-of-Book Tick Tracker

This block sits behind a byte-oriented payload extractor and turns a stream of already validated market ticks into a live view of the best buy and best sell price. Each tick occupies nine consecutive payload bytes. The block collects those bytes into parallel fields and decodes the side code. It then compares the tick against the stored best level for that side and replaces the level when the tick is at least as good.

Downstream logic reads the best bid and best ask, each with its quantity and a valid flag. A one-cycle `bbo_updated` pulse tells it when either level has just changed. The assembled tick is also presented for one cycle so that a consumer can log or forward it.

Top module: `tob_tracker`

## Requirements
- R1: After reset, `bid_valid`, `ask_valid`, `tick_valid` and `bbo_updated` are all low.
- R2: A tick is nine accepted bytes. Bytes 0..3 form the price and bytes 4..7 form the quantity, each most significant byte first; byte 8 is the side code. In the cycle after byte 8 is accepted, `tick_valid` is high for exactly one cycle, with `tick_price` and `tick_qty` holding the assembled values.
- R3: Side code 0x42 raises `tick_buy` and side code 0x53 raises `tick_sell`, alongside `tick_valid`. Any other code raises neither.
- R4: The first buy tick after reset sets the bid level and `bid_valid`. The first sell tick does the same for the ask level and `ask_valid`.
- R5: A buy tick with a price above the stored bid replaces the bid price and quantity. A buy tick with a lower price leaves the bid unchanged.
- R6: A sell tick with a price below the stored ask replaces the ask price and quantity. A sell tick with a higher price leaves the ask unchanged.
- R7: A tick at a price equal to the stored best on its side replaces that side's quantity and raises `bbo_updated`.
- R8: A tick whose side code is neither 0x42 nor 0x53 changes no book output and raises no `bbo_updated`.
- R9: `bbo_updated` is high for exactly one cycle, in the cycle after `tick_valid`. The new book values are visible in that same cycle. It is raised only when a level was written.
- R10: If `in_last` accompanies an accepted byte before the ninth byte of a tick, the partial tick is dropped and the next accepted byte is byte 0 of a new tick.
- R11: A byte is taken only in a cycle with `in_valid` high. Idle cycles inside a tick do not disturb assembly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Byte on `in_byte` is present this cycle |
| in_byte | input | 8 | Payload byte |
| in_last | input | 1 | Byte is the last of its stream |
| tick_valid | output | 1 | One-cycle strobe for an assembled tick |
| tick_price | output | 32 | Assembled price |
| tick_qty | output | 32 | Assembled quantity |
| tick_buy | output | 1 | Assembled tick is a buy |
| tick_sell | output | 1 | Assembled tick is a sell |
| bid_valid | output | 1 | A bid level is held |
| bid_price | output | 32 | Best bid price |
| bid_qty | output | 32 | Quantity at best bid |
| ask_valid | output | 1 | An ask level is held |
| ask_price | output | 32 | Best ask price |
| ask_qty | output | 32 | Quantity at best ask |
| bbo_updated | output | 1 | One-cycle pulse when a level was written |

## Verification
A byte counter that drifts by one shows within the next tick: the price and quantity come out rotated and the strobe fires on the wrong byte, so the bench compares every field one cycle after each ninth byte. A wrong comparison direction or a lost valid flag shows at the book outputs two cycles after the final byte. The bench feeds better, worse and equal prices on each side and compares the book against its own model. A pulse that is missing or stretched is caught by sampling `bbo_updated` in the update cycle and again in the cycle after it.

// File: rtl/tob_pkg.sv
// Package: shared widths and side codes for the top-of-book tracker.
// Assumes prices and quantities are whole bytes wide.
package tob_pkg;
    localparam int unsigned PRICE_W = 32;
    localparam int unsigned QTY_W   = 32;
    localparam logic [7:0]  CODE_BUY  = 8'h42;
    localparam logic [7:0]  CODE_SELL = 8'h53;

    typedef enum logic [1:0] {
        SIDE_NONE = 2'b00,
        SIDE_BUY  = 2'b01,
        SIDE_SELL = 2'b10
    } side_t;
endpackage

// File: rtl/tob_tick_asm.sv
// Module: collects bytes of one tick (price, quantity, side; multi-byte
// fields most significant byte first) into parallel fields and strobes
// them for one cycle after the final byte.
// Assumes: upstream already validated framing; in_last may cut a tick short.
module tob_tick_asm
    import tob_pkg::*;
#(
    parameter int unsigned P_W = PRICE_W,
    parameter int unsigned Q_W = QTY_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    input  logic [7:0]     in_byte,
    input  logic           in_last,
    output logic           t_valid,
    output logic [P_W-1:0] t_price,
    output logic [Q_W-1:0] t_qty,
    output side_t          t_side
);
    localparam int unsigned FIELD_W = P_W + Q_W;
    localparam int unsigned NBYTES  = FIELD_W / 8 + 1;
    localparam int unsigned CNT_W   = $clog2(NBYTES);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(NBYTES - 1);

    logic [CNT_W-1:0]   cnt;
    logic [FIELD_W-1:0] acc;
    side_t              side_dec;

    // Decode the incoming side code.
    always_comb begin
        if (in_byte == CODE_BUY)       side_dec = SIDE_BUY;
        else if (in_byte == CODE_SELL) side_dec = SIDE_SELL;
        else                           side_dec = SIDE_NONE;
    end

    // Count bytes, shift fields in, and emit the tick on its last byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            acc     <= '0;
            t_valid <= 1'b0;
            t_price <= '0;
            t_qty   <= '0;
            t_side  <= SIDE_NONE;
        end else begin
            t_valid <= 1'b0;
            if (in_valid) begin
                if (cnt == LAST_IDX) begin
                    cnt     <= '0;
                    t_valid <= 1'b1;
                    t_price <= acc[FIELD_W-1 -: P_W];
                    t_qty   <= acc[Q_W-1:0];
                    t_side  <= side_dec;
                end else if (in_last) begin
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                    acc <= {acc[FIELD_W-9:0], in_byte};
                end
            end
        end
    end
endmodule

// File: rtl/tob_level.sv
// Module: holds the best price and quantity for one side of the book.
// IS_BID selects "higher is better" (buy side) or "lower is better"
// (sell side). Equal prices overwrite the quantity. Empty accepts anything.
module tob_level #(
    parameter int unsigned P_W    = 32,
    parameter int unsigned Q_W    = 32,
    parameter bit          IS_BID = 1'b1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           hit,
    input  logic [P_W-1:0] price,
    input  logic [Q_W-1:0] qty,
    output logic           lvl_valid,
    output logic [P_W-1:0] lvl_price,
    output logic [Q_W-1:0] lvl_qty,
    output logic           changed
);
    logic at_least_as_good;

    // Choose the comparison direction for this side.
    generate
        if (IS_BID) begin : g_bid
            assign at_least_as_good = (price >= lvl_price);
        end else begin : g_ask
            assign at_least_as_good = (price <= lvl_price);
        end
    endgenerate

    logic take;
    // A tick is taken when it lands on this side and the level is empty or beaten/matched.
    assign take = hit && (!lvl_valid || at_least_as_good);

    // Store the new level and flag the change for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_valid <= 1'b0;
            lvl_price <= '0;
            lvl_qty   <= '0;
            changed   <= 1'b0;
        end else begin
            changed <= take;
            if (take) begin
                lvl_valid <= 1'b1;
                lvl_price <= price;
                lvl_qty   <= qty;
            end
        end
    end
endmodule

// File: rtl/tob_tracker.sv
// Module: top of the top-of-book tracker. Assembles ticks from a byte
// stream and maintains the best bid and best ask with a change pulse.
// Assumes: one byte per cycle at most; ticks are pre-validated upstream.
module tob_tracker
    import tob_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [7:0]   in_byte,
    input  logic         in_last,
    output logic         tick_valid,
    output logic [31:0]  tick_price,
    output logic [31:0]  tick_qty,
    output logic         tick_buy,
    output logic         tick_sell,
    output logic         bid_valid,
    output logic [31:0]  bid_price,
    output logic [31:0]  bid_qty,
    output logic         ask_valid,
    output logic [31:0]  ask_price,
    output logic [31:0]  ask_qty,
    output logic         bbo_updated
);
    side_t t_side;
    logic  bid_chg, ask_chg;

    tob_tick_asm #(.P_W(PRICE_W), .Q_W(QTY_W)) u_asm (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_byte  (in_byte),
        .in_last  (in_last),
        .t_valid  (tick_valid),
        .t_price  (tick_price),
        .t_qty    (tick_qty),
        .t_side   (t_side)
    );

    assign tick_buy  = tick_valid && (t_side == SIDE_BUY);
    assign tick_sell = tick_valid && (t_side == SIDE_SELL);

    tob_level #(.P_W(PRICE_W), .Q_W(QTY_W), .IS_BID(1'b1)) u_bid (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit       (tick_buy),
        .price     (tick_price),
        .qty       (tick_qty),
        .lvl_valid (bid_valid),
        .lvl_price (bid_price),
        .lvl_qty   (bid_qty),
        .changed   (bid_chg)
    );

    tob_level #(.P_W(PRICE_W), .Q_W(QTY_W), .IS_BID(1'b0)) u_ask (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit       (tick_sell),
        .price     (tick_price),
        .qty       (tick_qty),
        .lvl_valid (ask_valid),
        .lvl_price (ask_price),
        .lvl_qty   (ask_qty),
        .changed   (ask_chg)
    );

    assign bbo_updated = bid_chg || ask_chg;
endmodule

// File: rtl/tob_tracker_chk.sv
// Checker: temporal properties of tob_tracker, bound to every instance.
module tob_tracker_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        tick_valid,
    input logic        tick_buy,
    input logic        tick_sell,
    input logic        bid_valid,
    input logic [31:0] bid_price,
    input logic        ask_valid,
    input logic [31:0] ask_price,
    input logic        bbo_updated
);
    // R2: a tick strobe never lasts two cycles.
    p_tick_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick_valid |=> !tick_valid);
    // R3: a tick is never both buy and sell.
    p_side_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(tick_buy && tick_sell));
    // R4: once a side holds a level it keeps one.
    p_bid_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bid_valid |=> bid_valid);
    p_ask_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ask_valid |=> ask_valid);
    // R5: the best bid never falls.
    p_bid_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bid_valid && $past(bid_valid)) |-> (bid_price >= $past(bid_price)));
    // R6: the best ask never rises.
    p_ask_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ask_valid && $past(ask_valid)) |-> (ask_price <= $past(ask_price)));
    // R8: a tick with an unknown side code never produces an update.
    p_bad_side_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_valid && !tick_buy && !tick_sell) |=> !bbo_updated);
    // R9: the update pulse follows a tick strobe and lasts one cycle.
    p_upd_after_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bbo_updated |-> $past(tick_valid));
    p_upd_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bbo_updated |=> !bbo_updated);
endmodule

bind tob_tracker tob_tracker_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_valid  (tick_valid),
    .tick_buy    (tick_buy),
    .tick_sell   (tick_sell),
    .bid_valid   (bid_valid),
    .bid_price   (bid_price),
    .ask_valid   (ask_valid),
    .ask_price   (ask_price),
    .bbo_updated (bbo_updated)
);

// File: tb/tob_tracker_test.sv
// Directed bench for tob_tracker: one task per scenario, each checking itself.
module tob_tracker_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic        in_last = 1'b0;
    logic        tick_valid, tick_buy, tick_sell;
    logic [31:0] tick_price, tick_qty;
    logic        bid_valid, ask_valid, bbo_updated;
    logic [31:0] bid_price, bid_qty, ask_price, ask_qty;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    // Model of the book, driven only by the requirements.
    logic        m_bid_v = 1'b0, m_ask_v = 1'b0;
    logic [31:0] m_bid_p = '0, m_bid_q = '0, m_ask_p = '0, m_ask_q = '0;
    logic        m_upd;

    // Values seen around the last tick.
    logic        s_tv, s_buy, s_sell, s_upd, s_upd_after;
    logic [31:0] s_price, s_qty;

    tob_tracker uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .in_last(in_last), .tick_valid(tick_valid), .tick_price(tick_price),
        .tick_qty(tick_qty), .tick_buy(tick_buy), .tick_sell(tick_sell),
        .bid_valid(bid_valid), .bid_price(bid_price), .bid_qty(bid_qty),
        .ask_valid(ask_valid), .ask_price(ask_price), .ask_qty(ask_qty),
        .bbo_updated(bbo_updated)
    );

    always #10 clk = ~clk;

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            total = total + 1;
            bad = bad + 1;
            $display("FAIL watchdog: actual=%0d cycles expected<=100000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        total = total + 1;
        if (act !== exp) begin
            bad = bad + 1;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic put_byte(input logic [7:0] b, input logic last, input int gap);
        for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
        @(negedge clk);
        in_valid = 1'b1;
        in_byte  = b;
        in_last  = last;
    endtask

    // Apply a tick to the model following the requirements.
    task automatic model_apply(input logic [31:0] p, input logic [31:0] q, input logic [7:0] sd);
        m_upd = 1'b0;
        if (sd == 8'h42 && (!m_bid_v || p >= m_bid_p)) begin
            m_bid_v = 1'b1; m_bid_p = p; m_bid_q = q; m_upd = 1'b1;
        end
        if (sd == 8'h53 && (!m_ask_v || p <= m_ask_p)) begin
            m_ask_v = 1'b1; m_ask_p = p; m_ask_q = q; m_upd = 1'b1;
        end
    endtask

    // Send one nine-byte tick and capture the outputs in the two following cycles.
    task automatic send_tick(input logic [31:0] p, input logic [31:0] q,
                             input logic [7:0] sd, input int gap);
        for (int i = 0; i < 4; i++) put_byte(p[31-8*i -: 8], 1'b0, gap);
        for (int i = 0; i < 4; i++) put_byte(q[31-8*i -: 8], 1'b0, gap);
        put_byte(sd, 1'b1, gap);
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
        s_tv = tick_valid; s_buy = tick_buy; s_sell = tick_sell;
        s_price = tick_price; s_qty = tick_qty;
        @(negedge clk);
        s_upd = bbo_updated;
        @(negedge clk);
        s_upd_after = bbo_updated;
        model_apply(p, q, sd);
    endtask

    task automatic check_book(input string req);
        check(req, "bid_valid", 64'(bid_valid), 64'(m_bid_v));
        check(req, "bid_price", 64'(bid_price), 64'(m_bid_v ? m_bid_p : bid_price));
        check(req, "bid_qty",   64'(bid_qty),   64'(m_bid_v ? m_bid_q : bid_qty));
        check(req, "ask_valid", 64'(ask_valid), 64'(m_ask_v));
        check(req, "ask_price", 64'(ask_price), 64'(m_ask_v ? m_ask_p : ask_price));
        check(req, "ask_qty",   64'(ask_qty),   64'(m_ask_v ? m_ask_q : ask_qty));
        check(req, "bbo_updated", 64'(s_upd), 64'(m_upd));
        check("R9", "pulse width", 64'(s_upd_after), 64'd0);
    endtask

    task automatic t_reset_r1();
        @(negedge clk);
        check("R1", "bid_valid", 64'(bid_valid), 64'd0);
        check("R1", "ask_valid", 64'(ask_valid), 64'd0);
        check("R1", "tick_valid", 64'(tick_valid), 64'd0);
        check("R1", "bbo_updated", 64'(bbo_updated), 64'd0);
    endtask

    task automatic t_first_bid_r4();
        send_tick(32'h0000_2710, 32'h0000_03E8, 8'h42, 0);
        check("R2", "tick_valid", 64'(s_tv), 64'd1);
        check("R2", "tick_price", 64'(s_price), 64'h2710);
        check("R2", "tick_qty", 64'(s_qty), 64'h3E8);
        check("R3", "tick_buy", 64'(s_buy), 64'd1);
        check("R3", "tick_sell", 64'(s_sell), 64'd0);
        check_book("R4");
    endtask

    task automatic t_first_ask_r4();
        send_tick(32'h1122_3344, 32'h5566_7788, 8'h53, 0);
        check("R2", "tick_price order", 64'(s_price), 64'h11223344);
        check("R2", "tick_qty order", 64'(s_qty), 64'h55667788);
        check("R3", "tick_sell", 64'(s_sell), 64'd1);
        check_book("R4");
    endtask

    task automatic t_bid_moves_r5();
        send_tick(32'h0000_3000, 32'd7, 8'h42, 0);
        check_book("R5 higher");
        send_tick(32'h0000_2000, 32'd9, 8'h42, 0);
        check_book("R5 lower");
    endtask

    task automatic t_ask_moves_r6();
        send_tick(32'h1000_0000, 32'd5, 8'h53, 0);
        check_book("R6 lower");
        send_tick(32'h2000_0000, 32'd6, 8'h53, 0);
        check_book("R6 higher");
    endtask

    task automatic t_equal_r7();
        send_tick(32'h0000_3000, 32'd77, 8'h42, 0);
        check_book("R7 bid");
        send_tick(32'h1000_0000, 32'd88, 8'h53, 0);
        check_book("R7 ask");
    endtask

    task automatic t_bad_side_r8();
        send_tick(32'hFFFF_FFFF, 32'd1, 8'h58, 0);
        check("R8", "tick_valid", 64'(s_tv), 64'd1);
        check("R8", "no side", 64'({s_buy, s_sell}), 64'd0);
        check_book("R8");
    endtask

    task automatic t_partial_r10();
        for (int i = 0; i < 5; i++) put_byte(8'hEE, (i == 4), 0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            in_valid = 1'b0; in_last = 1'b0;
            check("R10", "no tick from partial", 64'(tick_valid), 64'd0);
        end
        send_tick(32'h0000_4000, 32'd12, 8'h42, 0);
        check("R10", "tick_price after cut", 64'(s_price), 64'h4000);
        check("R10", "tick_qty after cut", 64'(s_qty), 64'd12);
        check_book("R10");
    endtask

    task automatic t_gaps_r11();
        send_tick(32'h0F00_0000, 32'hABCD, 8'h53, 2);
        check("R11", "tick_price", 64'(s_price), 64'h0F000000);
        check("R11", "tick_qty", 64'(s_qty), 64'hABCD);
        check_book("R11");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset_r1();
        rst_n = 1'b1;
        t_reset_r1();
        t_first_bid_r4();
        t_first_ask_r4();
        t_bid_moves_r5();
        t_ask_moves_r6();
        t_equal_r7();
        t_bad_side_r8();
        t_partial_r10();
        t_gaps_r11();
        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule